// File: doc/BRIEF.md
# Raster-Timed Interrupt Burst Generator

This block produces a train of single-cycle interrupt requests placed at chosen points of the video raster. Light-gun style position sensing relies on such a train. The host arms the block with three values: a pulse count, a target line and a horizontal cycle offset. The first request lands one whole frame after the most recent frame start. The target line adds that many line periods, and the offset adds a further number of cycles. Every later request follows the one before it by exactly one line period, until the count is spent.

Frame and line periods are elaboration-time constants derived from the clock frequency parameter, with one pair per video standard (60 Hz with 263 lines, 50 Hz with 314 lines). A free-running cycle counter holds the current time. The block keeps the deadline as a start time plus a delay, and tests it with a subtraction that stays correct across counter wrap. Each request shows as a strobe. A companion status word carries a single set bit at position 10, ready to be ORed into an interrupt-status register. Acknowledge logic sits outside this block.

Top module: `raster_irq_gen`

## Requirements
- R1: After reset, `irq_set_o` is 0 and `irq_set_bits_o` is zero until an arm command arrives.
- R2: The frame period is CLK_HZ/60 cycles in NTSC mode (`pal_mode_i`=0) and CLK_HZ/50 in PAL mode (`pal_mode_i`=1). There are 263 lines per frame in NTSC mode and 314 in PAL mode. The line period is the frame period divided by the line count, rounded down.
- R3: Suppose `frame_start_i` is sampled at clock edge e, and an arm is sampled later than e and no later than the deadline. The first pulse is then high during the cycle that follows edge e+D-1, where D = frame period + floor(line × frame period / lines per frame) + offset.
- R4: With an arm count N ≥ 1, exactly N pulses occur. Consecutive pulses lie exactly one line period apart, and no further pulse follows the last one.
- R5: An arm with a count of 0 produces exactly one pulse.
- R6: An arm sampled while a burst is pending replaces its deadline, line period and remaining count. Pulses already issued stay as they were, and only the new schedule goes on.
- R7: `irq_set_bits_o` equals 32'h0000_0400 (only bit 10 set) in every cycle in which `irq_set_o` is 1, and zero otherwise.
- R8: The video standard is taken from `pal_mode_i` in the arm cycle, and later changes of that input do not alter a running burst. Deadlines are met correctly when the cycle counter wraps between the frame start and a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start_i | input | 1 | One-cycle strobe marking the start of a video frame |
| pal_mode_i | input | 1 | Video standard select: 0 = NTSC timing, 1 = PAL timing |
| arm_i | input | 1 | One-cycle arm command |
| arm_count_i | input | N_W | Number of pulses (0 is treated as 1) |
| arm_line_i | input | Y_W | Target line within the next frame |
| arm_xoff_i | input | X_W | Extra cycle offset added to the first deadline |
| irq_set_o | output | 1 | Single-cycle interrupt request strobe |
| irq_set_bits_o | output | STATUS_W | Status-register set mask, bit IRQ_BIT set during a strobe |

## Verification
The bench builds the block with CLK_HZ = 94200, which gives frames of 1570 and 1884 cycles and line periods of 5 and 6. A full frame plus a late line therefore fits in a few thousand cycles, so both standards can be swept across target lines, offsets and counts in one run. It also narrows the cycle counter to 13 bits, so the counter wraps every 8192 cycles. Many bursts in the sweep therefore straddle a wrap, and the wrap-safe deadline test is exercised rather than assumed. Expected pulse times come from the raster formula evaluated in the bench, and the bench compares them with the observed pulse train.

// File: rtl/raster_irq_pkg.sv
package raster_irq_pkg;

  localparam int unsigned NTSC_RATE  = 60;
  localparam int unsigned PAL_RATE   = 50;
  localparam int unsigned NTSC_LINES = 263;
  localparam int unsigned PAL_LINES  = 314;

  typedef enum logic {
    MODE_NTSC = 1'b0,
    MODE_PAL  = 1'b1
  } vmode_e;

  // Cycles in one frame for a given refresh rate.
  function automatic longint unsigned frame_cycles(input longint unsigned clk_hz,
                                                   input longint unsigned rate);
    return clk_hz / rate;
  endfunction

  // Cycles in one scan line, truncated.
  function automatic longint unsigned line_cycles(input longint unsigned frame,
                                                  input longint unsigned lines);
    return frame / lines;
  endfunction

  // Offset of a target line inside a frame, scaled before the division.
  function automatic longint unsigned line_offset(input longint unsigned line_idx,
                                                  input longint unsigned frame,
                                                  input longint unsigned lines);
    return (line_idx * frame) / lines;
  endfunction

endpackage

// File: rtl/raster_cycle_clock.sv
module raster_cycle_clock #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start_i,
  output logic [CNT_W-1:0] now_o,
  output logic [CNT_W-1:0] frame_base_o
);

  logic [CNT_W-1:0] now_q;
  logic [CNT_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now_q  <= '0;
      base_q <= '0;
    end else begin
      now_q <= now_q + 1'b1;
      if (frame_start_i) base_q <= now_q;
    end
  end

  assign now_o        = now_q;
  assign frame_base_o = base_q;

  // R8: time advances by one every cycle, wrapping freely
  assert_cycle_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> now_q == $past(now_q) + 1'b1);

  // R3: the frame base is the time at which the strobe was sampled
  assert_base_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> base_q == $past(now_q));

endmodule

// File: rtl/raster_deadline_calc.sv
module raster_deadline_calc
  import raster_irq_pkg::*;
#(
  parameter int unsigned CLK_HZ = 33868800,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned Y_W    = 9,
  parameter int unsigned X_W    = 12
) (
  input  logic             pal_i,
  input  logic [Y_W-1:0]   line_idx_i,
  input  logic [X_W-1:0]   xoff_i,
  output logic [CNT_W-1:0] first_delay_o,
  output logic [CNT_W-1:0] line_period_o
);

  logic [CNT_W-1:0] delay_mode [2];
  logic [CNT_W-1:0] line_mode  [2];

  for (genvar m = 0; m < 2; m++) begin : g_mode
    localparam longint unsigned RATE  = (m == int'(MODE_PAL)) ? PAL_RATE  : NTSC_RATE;
    localparam longint unsigned LINES = (m == int'(MODE_PAL)) ? PAL_LINES : NTSC_LINES;
    localparam longint unsigned FRAME = frame_cycles(longint'(CLK_HZ), RATE);
    localparam longint unsigned LINE  = line_cycles(FRAME, LINES);

    assign delay_mode[m] = CNT_W'(FRAME
                                  + line_offset(longint'(line_idx_i), FRAME, LINES)
                                  + longint'(xoff_i));
    assign line_mode[m]  = CNT_W'(LINE);
  end

  assign first_delay_o = delay_mode[pal_i];
  assign line_period_o = line_mode[pal_i];

endmodule

// File: rtl/raster_burst_ctrl.sv
module raster_burst_ctrl #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned N_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] now_i,
  input  logic [CNT_W-1:0] frame_base_i,
  input  logic             arm_i,
  input  logic [N_W-1:0]   arm_count_i,
  input  logic [CNT_W-1:0] arm_delay_i,
  input  logic [CNT_W-1:0] arm_line_i,
  output logic             fire_o,
  output logic             active_o
);

  logic             active_q;
  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] delay_q;
  logic [CNT_W-1:0] line_q;
  logic [N_W-1:0]   remaining_q;

  // Named internal events
  logic [CNT_W-1:0] elapsed;
  logic [CNT_W-1:0] next_start;
  logic             due;
  logic             last_pulse;

  assign elapsed    = now_i - start_q;
  assign due        = elapsed >= delay_q;
  assign next_start = start_q + delay_q;
  assign last_pulse = remaining_q <= N_W'(1);
  assign fire_o     = active_q && due;
  assign active_o   = active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      start_q     <= '0;
      delay_q     <= '0;
      line_q      <= '0;
      remaining_q <= '0;
    end else if (arm_i) begin
      active_q    <= 1'b1;
      start_q     <= frame_base_i;
      delay_q     <= arm_delay_i;
      line_q      <= arm_line_i;
      remaining_q <= arm_count_i;
    end else if (fire_o) begin
      if (last_pulse) begin
        active_q <= 1'b0;
      end else begin
        remaining_q <= remaining_q - 1'b1;
        start_q     <= next_start;
        delay_q     <= line_q;
      end
    end
  end

  // R6: an arm always installs the new schedule
  assert_rearm_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> active_q && remaining_q == $past(arm_count_i)
              && delay_q == $past(arm_delay_i) && start_q == $past(frame_base_i));

  // R4: the final pulse of a burst leaves the block idle
  assert_burst_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o && !arm_i && last_pulse |=> !active_q);

  // R4: an intermediate pulse schedules the next one a line later
  assert_next_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o && !arm_i && !last_pulse |=> active_q && delay_q == $past(line_q)
                                        && start_q == $past(next_start)
                                        && remaining_q == $past(remaining_q) - 1'b1);

  // R1: an idle block stays idle without an arm
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q && !arm_i |=> !active_q);

endmodule

// File: rtl/raster_irq_gen.sv
module raster_irq_gen
  import raster_irq_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 33868800,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned N_W      = 8,
  parameter int unsigned Y_W      = 9,
  parameter int unsigned X_W      = 12,
  parameter int unsigned STATUS_W = 32,
  parameter int unsigned IRQ_BIT  = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start_i,
  input  logic                pal_mode_i,
  input  logic                arm_i,
  input  logic [N_W-1:0]      arm_count_i,
  input  logic [Y_W-1:0]      arm_line_i,
  input  logic [X_W-1:0]      arm_xoff_i,
  output logic                irq_set_o,
  output logic [STATUS_W-1:0] irq_set_bits_o
);

  localparam logic [STATUS_W-1:0] IRQ_MASK = STATUS_W'(1) << IRQ_BIT;

  logic [CNT_W-1:0] now;
  logic [CNT_W-1:0] frame_base;
  logic [CNT_W-1:0] arm_delay;
  logic [CNT_W-1:0] arm_line_period;
  logic             fire;
  logic             active;

  raster_cycle_clock #(.CNT_W(CNT_W)) u_clock (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start_i(frame_start_i),
    .now_o        (now),
    .frame_base_o (frame_base)
  );

  raster_deadline_calc #(
    .CLK_HZ(CLK_HZ), .CNT_W(CNT_W), .Y_W(Y_W), .X_W(X_W)
  ) u_calc (
    .pal_i        (pal_mode_i),
    .line_idx_i   (arm_line_i),
    .xoff_i       (arm_xoff_i),
    .first_delay_o(arm_delay),
    .line_period_o(arm_line_period)
  );

  raster_burst_ctrl #(.CNT_W(CNT_W), .N_W(N_W)) u_burst (
    .clk         (clk),
    .rst_n       (rst_n),
    .now_i       (now),
    .frame_base_i(frame_base),
    .arm_i       (arm_i),
    .arm_count_i (arm_count_i),
    .arm_delay_i (arm_delay),
    .arm_line_i  (arm_line_period),
    .fire_o      (fire),
    .active_o    (active)
  );

  assign irq_set_o      = fire;
  assign irq_set_bits_o = fire ? IRQ_MASK : '0;

  // R7: the status word carries at most the interrupt bit
  assert_status_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_set_bits_o) && ((irq_set_bits_o & ~IRQ_MASK) == '0));

  // R1: a strobe only while a burst is pending
  assert_strobe_active_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set_o |-> active);

endmodule

// File: tb/tb_raster_irq_gen.sv
module tb_raster_irq_gen;

  localparam int CLK_PERIOD = 10;
  localparam int unsigned CLK_HZ = 94200;
  localparam int unsigned CNT_W  = 13;
  localparam int N_W = 8;
  localparam int Y_W = 9;
  localparam int X_W = 12;
  localparam int MAXLOG = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic pal_mode = 1'b0;
  logic arm = 1'b0;
  logic [N_W-1:0] arm_count = '0;
  logic [Y_W-1:0] arm_line = '0;
  logic [X_W-1:0] arm_xoff = '0;
  logic irq_set;
  logic [31:0] irq_bits;

  int pcyc = 0;
  int fire_at [MAXLOG];
  int nfires = 0;
  int bits_bad = 0;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) pcyc <= pcyc + 1;

  raster_irq_gen #(
    .CLK_HZ(CLK_HZ), .CNT_W(CNT_W), .N_W(N_W), .Y_W(Y_W), .X_W(X_W)
  ) dut (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start), .pal_mode_i(pal_mode),
    .arm_i(arm), .arm_count_i(arm_count), .arm_line_i(arm_line), .arm_xoff_i(arm_xoff),
    .irq_set_o(irq_set), .irq_set_bits_o(irq_bits)
  );

  always @(negedge clk) begin
    if (irq_set) begin
      if (nfires < MAXLOG) fire_at[nfires] = pcyc;
      nfires = nfires + 1;
    end
    if (irq_bits !== (irq_set ? 32'h0000_0400 : 32'h0)) bits_bad = bits_bad + 1;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Raster arithmetic restated from the requirements
  function automatic int frame_len(input bit pal);
    return int'(CLK_HZ) / (pal ? 50 : 60);
  endfunction
  function automatic int lines_of(input bit pal);
    return pal ? 314 : 263;
  endfunction
  function automatic int line_len(input bit pal);
    return frame_len(pal) / lines_of(pal);
  endfunction
  function automatic int first_gap(input bit pal, input int y, input int x);
    longint prod;
    prod = longint'(y) * longint'(frame_len(pal));
    return frame_len(pal) + int'(prod / longint'(lines_of(pal))) + x;
  endfunction

  task automatic frame_then_arm(input bit pal, input int cnt, input int y, input int x,
                                output int p);
    @(negedge clk);
    frame_start = 1'b1;
    p = pcyc;
    @(negedge clk);
    frame_start = 1'b0;
    pal_mode = pal;
    arm = 1'b1;
    arm_count = N_W'(cnt);
    arm_line = Y_W'(y);
    arm_xoff = X_W'(x);
    @(negedge clk);
    arm = 1'b0;
    pal_mode = ~pal;  // R8: later changes must not matter
  endtask

  task automatic run_burst(input bit pal, input int cnt, input int y, input int x);
    int p, d, l, n_exp;
    nfires = 0;
    bits_bad = 0;
    frame_then_arm(pal, cnt, y, x, p);
    d = first_gap(pal, y, x);
    l = line_len(pal);
    n_exp = (cnt == 0) ? 1 : cnt;
    repeat (d + (n_exp + 3) * l + 10) @(negedge clk);
    if (cnt == 0) check(nfires == 1, "R5 pulse count for zero arm", nfires, 1);
    else          check(nfires == n_exp, "R4 pulse count", nfires, n_exp);
    if (nfires > 0)
      check(fire_at[0] == p + d, "R3 R8 first pulse time", fire_at[0] - p, d);
    for (int k = 1; k < nfires && k < MAXLOG; k++)
      check(fire_at[k] - fire_at[k-1] == l, "R2 R4 line spacing",
            fire_at[k] - fire_at[k-1], l);
    check(bits_bad == 0, "R7 status word", bits_bad, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    int ys [4] = '{0, 1, 37, 262};
    int xs [3] = '{0, 5, 211};
    int cs [3] = '{0, 1, 4};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    nfires = 0;
    bits_bad = 0;
    repeat (60) @(negedge clk);
    check(nfires == 0, "R1 no pulse after reset", nfires, 0);
    check(bits_bad == 0 && irq_bits == 32'h0, "R1 R7 status idle", irq_bits, 0);

    for (int pal = 0; pal < 2; pal++)
      for (int yi = 0; yi < 4; yi++)
        for (int ci = 0; ci < 3; ci++)
          run_burst(pal[0], cs[ci], ys[yi], xs[(yi + ci) % 3]);

    // R6: re-arm in the middle of a burst
    begin
      int p, d1, d2, l;
      nfires = 0;
      frame_then_arm(1'b0, 5, 10, 0, p);
      d1 = first_gap(1'b0, 10, 0);
      l = line_len(1'b0);
      while (pcyc < p + d1 + l + 2) @(negedge clk);
      pal_mode = 1'b0;
      arm = 1'b1;
      arm_count = N_W'(2);
      arm_line = Y_W'(30);
      arm_xoff = X_W'(4);
      @(negedge clk);
      arm = 1'b0;
      d2 = first_gap(1'b0, 30, 4);
      repeat (d2 + 6 * l) @(negedge clk);
      check(nfires == 4, "R6 pulses after re-arm", nfires, 4);
      if (nfires == 4) begin
        check(fire_at[1] == p + d1 + l, "R6 old second pulse", fire_at[1] - p, d1 + l);
        check(fire_at[2] == p + d2, "R6 new first pulse", fire_at[2] - p, d2);
        check(fire_at[3] == p + d2 + l, "R6 new second pulse", fire_at[3] - p, d2 + l);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule